// File: doc/BRIEF.md
# Addressable LED Serial Bit Encoder

This block drives a chain of addressable RGB or RGBW LEDs over one data wire. The host writes whole pixel colour words into a small internal queue, one word per write. A framing state machine takes each word out of the queue on its own and sends every bit as three equal time slots. The first slot is high, the middle slot carries the bit and the last slot is low. The host only stores raw colour bits, and no software has to expand or shift them.

A clock divider parameter sets how many system clocks make one slot. For example, 20 clocks at 48 MHz give slots of about 417 ns and a bit time of about 1.25 us. A mode input chooses whether each word holds 24 colour bits (RGB) or 32 colour bits (RGBW). When the queue runs dry, the line is held low for a parameterised latch gap so the strip takes up the new colours. The busy flag drops only after that gap. A level-sensitive interrupt asks for more words while the queue holds fewer words than a threshold set on an input.

Top module: `led_bit_encoder`

## Requirements
- R1: While reset is active: `dout` is 0, `busy` is 0, `wr_ready` is 1, and `irq_low` equals (0 < `ae_level`).
- R2: Each bit takes 3*SLOT_CLKS clocks, made of three slots of SLOT_CLKS clocks each. `dout` is 1 for the whole first slot and 0 for the whole third slot.
- R3: The middle slot of a bit shows that bit's value. Bits leave most significant first, so a 1 gives the slot pattern 1,1,0 and a 0 gives 1,0,0.
- R4: The word length is taken from `mode_rgbw` at the clock edge where the word leaves the queue. With 0, only `wr_data[23:0]` is sent (24 bits, bit 23 first) and bits 31:24 have no effect. With 1, all 32 bits are sent, bit 31 first.
- R5: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. Words are sent in the order they were accepted. `wr_ready` is 0 exactly when the queue holds FIFO_DEPTH words.
- R6: When a word finishes and the queue is not empty, the first slot of the next word begins on the very next clock, with no gap between words.
- R7: When a word finishes and the queue is empty, `dout` stays 0 and `busy` stays 1 for GAP_CLKS clocks, and then `busy` falls. A word written during the gap is sent only after the gap. `busy` is 1 from the first slot of a word to the end of its gap.
- R8: `irq_low` is 1 exactly while the number of words in the queue is below `ae_level`, and it follows the count as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Pixel word write request |
| wr_data | input | 32 | Pixel colour word |
| wr_ready | output | 1 | Queue can accept a word |
| mode_rgbw | input | 1 | 0: 24-bit words, 1: 32-bit words |
| ae_level | input | $clog2(FIFO_DEPTH+1) | Refill threshold in words |
| irq_low | output | 1 | Queue level below threshold (level) |
| busy | output | 1 | Transmitting or in latch gap |
| dout | output | 1 | Serial LED data line |

## Verification
On every cycle, the assertions check four things. The line rises only at the start of a first slot. The line stays low outside transmission. `busy` falls only when a latch gap ends. The queue count changes only by the accepted writes and the pops, and a pop never hits an empty queue.

Some behaviour needs the bench's cycle-exact reference model, run across its scenarios:
- the slot lengths and the bit values in the middle slots;
- MSB-first order in both word lengths;
- the mode being taken when a word is loaded;
- gapless hand-over between words;
- the exact gap length;
- writes that arrive during the gap;
- the threshold interrupt as the threshold changes.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

    localparam int unsigned PIX_W = 32;
    localparam int unsigned RGB_W = 24;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_SEND = 2'd1,
        FR_GAP  = 2'd2
    } frame_state_e;

    // Left-justify a pixel word so the first bit to send is always bit PIX_W-1.
    function automatic logic [PIX_W-1:0] align_pixel(input logic [PIX_W-1:0] raw,
                                                     input logic wide);
        return wide ? raw : {raw[RGB_W-1:0], {(PIX_W-RGB_W){1'b0}}};
    endfunction

    // Index of the first bit sent, counting down to zero.
    function automatic logic [4:0] top_bit(input logic wide);
        return wide ? 5'(PIX_W-1) : 5'(RGB_W-1);
    endfunction

endpackage

// File: rtl/led_word_fifo.sv
module led_word_fifo #(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned LVL_W = $clog2(DEPTH+1),
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [led_enc_pkg::PIX_W-1:0] push_data,
    input  logic                          pop,
    output logic [led_enc_pkg::PIX_W-1:0] head,
    output logic                          empty,
    output logic                          full,
    output logic [LVL_W-1:0]              level
);
    import led_enc_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][PIX_W-1:0] mem;
        logic [PTR_W-1:0]            wp;
        logic [PTR_W-1:0]            rp;
        logic [LVL_W-1:0]            lvl;
    } fifo_s;

    fifo_s q, d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d = q;
        if (push) begin
            d.mem[q.wp] = push_data;
            d.wp        = bump(q.wp);
        end
        if (pop) begin
            d.rp = bump(q.rp);
        end
        d.lvl = q.lvl + LVL_W'(push) - LVL_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign empty = (q.lvl == '0);
    assign full  = (q.lvl == LVL_W'(DEPTH));
    assign level = q.lvl;

    // R5: the count moves only by accepted writes and pops
    a_r5_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q.lvl == $past(q.lvl) + LVL_W'($past(push)) - LVL_W'($past(pop))));

    // R5: never more words than storage
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.lvl <= LVL_W'(DEPTH));

endmodule

// File: rtl/led_slot_timer.sv
module led_slot_timer #(
    parameter  int unsigned SLOT_CLKS = 20,
    localparam int unsigned CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s q, d;

    always_comb begin
        tick = run && (q.cnt == CW'(SLOT_CLKS-1));
        d    = q;
        if (!run || tick) d.cnt = '0;
        else              d.cnt = q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: slot counter stays inside one slot length
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(SLOT_CLKS-1));

    // R2: counter restarts from zero whenever the line is not sending
    a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q.cnt == '0));

endmodule

// File: rtl/led_frame_fsm.sv
module led_frame_fsm #(
    parameter  int unsigned GAP_CLKS = 2400,
    localparam int unsigned GW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          fifo_empty,
    input  logic [led_enc_pkg::PIX_W-1:0] head,
    input  logic                          mode_wide,
    output logic                          pop,
    output logic                          run,
    output logic                          busy,
    output logic                          dout
);
    import led_enc_pkg::*;

    typedef struct packed {
        frame_state_e      st;
        logic [1:0]        slot;
        logic [4:0]        bit_idx;
        logic [PIX_W-1:0]  shreg;
        logic [GW-1:0]     gap;
        logic              dout;
    } fsm_s;

    fsm_s q, d;
    logic take;

    always_comb begin
        d    = q;
        take = 1'b0;
        unique case (q.st)
            FR_IDLE: begin
                take = !fifo_empty;
            end
            FR_SEND: begin
                if (tick) begin
                    if (q.slot != 2'd2) begin
                        d.slot = q.slot + 2'd1;
                    end else if (q.bit_idx != 5'd0) begin
                        d.slot    = 2'd0;
                        d.bit_idx = q.bit_idx - 5'd1;
                        d.shreg   = q.shreg << 1;
                    end else if (!fifo_empty) begin
                        take = 1'b1;
                    end else begin
                        d.st  = FR_GAP;
                        d.gap = '0;
                    end
                end
            end
            FR_GAP: begin
                if (q.gap == GW'(GAP_CLKS-1)) d.st  = FR_IDLE;
                else                          d.gap = q.gap + GW'(1);
            end
            default: d.st = FR_IDLE;
        endcase

        if (take) begin
            d.st      = FR_SEND;
            d.slot    = 2'd0;
            d.bit_idx = top_bit(mode_wide);
            d.shreg   = align_pixel(head, mode_wide);
        end
        pop    = take;
        d.dout = (d.st == FR_SEND) &&
                 ((d.slot == 2'd0) || ((d.slot == 2'd1) && d.shreg[PIX_W-1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run  = (q.st == FR_SEND);
    assign busy = (q.st != FR_IDLE);
    assign dout = q.dout;

    // R2: the line only rises at the start of a first slot
    a_r2_rise_at_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.dout) |-> (q.st == FR_SEND && q.slot == 2'd0));

    // R7: quiet line outside transmission
    a_r7_low_outside_send: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != FR_SEND) |-> !q.dout);

    // R7: busy is released only at the end of a latch gap
    a_r7_busy_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(q.st) == FR_GAP));

endmodule

// File: rtl/led_bit_encoder.sv
module led_bit_encoder #(
    parameter  int unsigned SLOT_CLKS  = 20,
    parameter  int unsigned GAP_CLKS   = 2400,
    parameter  int unsigned FIFO_DEPTH = 8,
    localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    output logic             wr_ready,
    input  logic             mode_rgbw,
    input  logic [LVL_W-1:0] ae_level,
    output logic             irq_low,
    output logic             busy,
    output logic             dout
);
    import led_enc_pkg::*;

    logic             fifo_empty, fifo_full, pop, run, tick, push;
    logic [PIX_W-1:0] head;
    logic [LVL_W-1:0] fifo_lvl;

    assign wr_ready = !fifo_full;
    assign push     = wr_valid && wr_ready;
    assign irq_low  = (fifo_lvl < ae_level);

    led_word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .level     (fifo_lvl)
    );

    led_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    led_frame_fsm #(.GAP_CLKS(GAP_CLKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fifo_empty (fifo_empty),
        .head       (head),
        .mode_wide  (mode_rgbw),
        .pop        (pop),
        .run        (run),
        .busy       (busy),
        .dout       (dout)
    );

    // R6: a word is taken only when the queue holds one
    a_r6_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);

    // R7: busy never drops while the slot timer is running
    a_r7_busy_covers_run: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> busy);

endmodule

// File: tb/led_bit_encoder_tb_top.sv
module led_bit_encoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT  = 3;
    localparam int GAP   = 25;
    localparam int DEPTH = 4;
    localparam int LW    = $clog2(DEPTH+1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_valid;
    logic [31:0]   wr_data;
    logic          wr_ready;
    logic          mode_rgbw;
    logic [LW-1:0] ae_level;
    logic          irq_low, busy, dout;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    led_bit_encoder #(.SLOT_CLKS(SLOT), .GAP_CLKS(GAP), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .mode_rgbw(mode_rgbw), .ae_level(ae_level),
        .irq_low(irq_low), .busy(busy), .dout(dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: a queue of words and a cycle counter per word
    logic [31:0] mq[$];
    int          m_st;     // 0 idle, 1 sending, 2 gap
    int          m_cyc;
    int          m_gap;
    int          m_len;
    logic [31:0] m_word;

    task automatic m_load();
        m_len  = mode_rgbw ? 32 : 24;
        m_word = mode_rgbw ? mq[0] : {8'h00, mq[0][23:0]};
        void'(mq.pop_front());
        m_cyc  = 0;
        m_st   = 1;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete();
            m_st = 0; m_cyc = 0; m_gap = 0; m_len = 24; m_word = '0;
        end else begin
            int sz0;
            sz0 = mq.size();
            case (m_st)
                0: if (mq.size() > 0) m_load();
                1: begin
                    m_cyc++;
                    if (m_cyc == m_len*3*SLOT) begin
                        if (mq.size() > 0) m_load();
                        else begin m_st = 2; m_gap = 0; end
                    end
                end
                default: begin
                    if (m_gap == GAP-1) m_st = 0;
                    else m_gap++;
                end
            endcase
            if (wr_valid && sz0 < DEPTH) mq.push_back(wr_data);
        end
    end

    // Compare every output on every falling edge
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            int   b, s;
            logic e;
            string tag;
            e = 1'b0; tag = "R7";
            if (m_st == 1) begin
                b = m_cyc / (3*SLOT);
                s = (m_cyc / SLOT) % 3;
                if (s == 0)      begin e = 1'b1; tag = "R2 R6"; end
                else if (s == 1) begin e = m_word[m_len-1-b]; tag = "R3 R4"; end
                else             begin e = 1'b0; tag = "R2 R6"; end
            end
            check(dout === e, tag, "dout", dout, e);
            check(busy === (m_st != 0), "R7", "busy", busy, (m_st != 0));
            check(wr_ready === (mq.size() < DEPTH), "R5", "wr_ready", wr_ready, (mq.size() < DEPTH));
            check(irq_low === (mq.size() < ae_level), "R8", "irq_low", irq_low, (mq.size() < ae_level));
        end
    end

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_data  = 32'hDEAD_BEEF;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || m_st != 0 || mq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; mode_rgbw = 1'b0; ae_level = LW'(2);
        repeat (3) @(negedge clk);
        // R1: reset values
        check(dout === 1'b0,     "R1", "dout",     dout, 0);
        check(busy === 1'b0,     "R1", "busy",     busy, 0);
        check(wr_ready === 1'b1, "R1", "wr_ready", wr_ready, 1);
        check(irq_low === 1'b1,  "R1", "irq_low",  irq_low, 1);
        rst_n  = 1'b1;
        cmp_en = 1'b1;

        // R4: 24-bit word, upper byte junk must not appear
        push_word(32'hFFA5_C30F);
        wait_idle();

        // R6 R3: 32-bit words back to back, edge patterns
        mode_rgbw = 1'b1;
        push_word(32'h8000_0001);
        push_word(32'hFFFF_FFFF);
        push_word(32'h0000_0000);
        push_word(32'h5A5A_A5A5);
        push_word(32'h1234_5678);
        // R5: queue fills while the first word is on the line
        @(negedge clk);
        check(wr_ready === 1'b0, "R5", "wr_ready when full", wr_ready, 0);
        wait_idle();

        // R4: mode changes mid-word affect only the next load
        push_word(32'hC001_D00D);
        push_word(32'hAB12_3456);
        repeat (40) @(negedge clk);
        mode_rgbw = 1'b0;
        wait_idle();

        // R7: write arriving during the latch gap waits for the gap to end
        push_word(32'h0000_0003);
        @(negedge clk);
        while (m_st != 2) @(negedge clk);
        repeat (5) @(negedge clk);
        push_word(32'h00F0_0F0F);
        wait_idle();

        // R8: threshold edges
        ae_level = LW'(0);
        push_word(32'h0011_2233);
        wait_idle();
        ae_level = LW'(DEPTH);
        mode_rgbw = 1'b1;
        for (int i = 0; i < 5; i++) push_word(32'h0101_0101 * (i + 1));
        wait_idle();

        cmp_en = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule